// File: doc/BRIEF.md
# SPI Command/Data Transmit Queue

This block is the transmit side queue that sits in front of an SPI shift engine. Software writes a single push word that carries a command field and a data field together. The pair is stored as one entry, and the engine takes one entry per frame by pulsing a pop request. The oldest entry is always on the head outputs. Entries leave only by being popped or when the whole queue is flushed. Three status outputs follow the fill level: a not-full flag, a sticky underflow flag and a fill counter. Internal read and write pointers are not visible outside the block.

A bypass input shrinks the queue to a single-entry double buffer. The status outputs keep the same meaning in that mode, measured against a capacity of one. The flush input is ignored while bypass is set. Bypass must be settled before the first push or pop after reset. A change made while the queue is in use has no defined result.

A three-state controller tracks occupancy. The states are Q_EMPTY, Q_PART and Q_FULL, where full means the counter equals the active capacity. The transitions are:
- fill: Q_EMPTY to Q_PART.
- fill_last: Q_EMPTY or Q_PART to Q_FULL.
- drain: Q_FULL or Q_PART to Q_PART.
- drain_last: to Q_EMPTY.
- flush: any state to Q_EMPTY.
- hold: no change.

In bypass mode, fill_last is taken directly from Q_EMPTY.

Top module: `spi_txq`

## Requirements
- R1: After reset the counter is 0, not-full is 1, underflow is 0 and head-valid is 0.
- R2: A push accepted while the counter is below capacity stores its command and data as one entry and raises the counter by one on the next clock.
- R3: Entries leave in first-in, first-out order. The head outputs show the oldest entry while head-valid is 1, and an accepted pop advances to the next entry on the next clock.
- R4: A push while the counter equals capacity is dropped. The counter and all stored entries are unchanged.
- R5: Push and pop acceptance are both decided on the counter at the start of the cycle. When both are accepted, the counter is unchanged.
- R6: A pop while the counter is 0 is ignored and sets the sticky underflow flag. The flag stays set until a clear strobe. When a set and a clear fall in the same cycle, the set wins.
- R7: In normal mode, a flush empties the queue on the next clock. Any push or pop in the same cycle is discarded.
- R8: With bypass set, the capacity is 1. Not-full drops after one push, and a second push is dropped until a pop.
- R9: With bypass set, the flush input has no effect on the counter or the stored entry.
- R10: Not-full is 1 exactly when the counter is below the active capacity: 16 in normal mode, 1 with bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_i | input | 1 | Single-entry buffer mode; settle before first access |
| flush_i | input | 1 | Discard all entries (normal mode only) |
| push_i | input | 1 | Push request |
| push_cmd_i | input | 16 | Command field of pushed word |
| push_data_i | input | 16 | Data field of pushed word |
| pop_i | input | 1 | Pop request from the shift engine |
| uflow_clr_i | input | 1 | Write-one-to-clear strobe for underflow |
| head_valid_o | output | 1 | Head entry present |
| head_cmd_o | output | 16 | Command field of oldest entry |
| head_data_o | output | 16 | Data field of oldest entry |
| not_full_o | output | 1 | Counter below capacity |
| uflow_o | output | 1 | Sticky underflow flag |
| count_o | output | 5 | Number of stored entries |

## Verification
The assertions take for granted that bypass changes only while reset is held. Under that assumption, the capacity seen by the pointers, the counter and the state register stays fixed between resets. The bench therefore sets bypass only inside its reset task. It then keeps it constant through each phase, while push, pop, flush and clear are driven freely, including into the full and empty corners.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
    parameter int CMD_W  = 16;
    parameter int DATA_W = 16;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] data;
    } txq_entry_t;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } txq_state_e;
endpackage

// File: rtl/txq_ptr.sv
module txq_ptr #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             clr_i,
    input  logic [PTR_W-1:0] last_i,
    output logic [PTR_W-1:0] ptr_o
);
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_nx;

    always_comb begin
        ptr_nx = ptr_q;
        if (clr_i) begin
            ptr_nx = '0;
        end else if (adv_i) begin
            ptr_nx = (ptr_q >= last_i) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_nx;
    end

    assign ptr_o = ptr_q;

    // R3
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= last_i);
endmodule

// File: rtl/txq_store.sv
module txq_store
    import spi_txq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  txq_entry_t       wr_word_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output txq_entry_t       rd_word_o
);
    txq_entry_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit;
        assign hit = wr_en_i && (wr_idx_i == PTR_W'(g));
        always_ff @(posedge clk) begin
            if (!rst_n)   slot_q[g] <= '0;
            else if (hit) slot_q[g] <= wr_word_i;
        end
    end

    assign rd_word_o = slot_q[rd_idx_i];

    // R2
    write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> slot_q[$past(wr_idx_i)] == $past(wr_word_i));
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import spi_txq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass_i,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             uflow_clr_i,
    output logic             push_ok_o,
    output logic             pop_ok_o,
    output logic             flush_eff_o,
    output logic [PTR_W-1:0] last_o,
    output logic             head_valid_o,
    output logic             not_full_o,
    output logic             uflow_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CAP_N = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_B = CNT_W'(1);

    txq_state_e       state_q, state_nx;
    logic [CNT_W-1:0] count_q, count_nx;
    logic             uflow_q, uflow_nx;
    logic [CNT_W-1:0] cap;
    logic             push_ok, pop_ok, flush_eff, uf_set;

    assign cap       = bypass_i ? CAP_B : CAP_N;
    assign flush_eff = flush_i && !bypass_i;
    assign push_ok   = push_i && !flush_eff && (count_q < cap);
    assign pop_ok    = pop_i && !flush_eff && (count_q != '0);
    assign uf_set    = pop_i && !flush_eff && (count_q == '0);

    always_comb begin
        count_nx = count_q;
        if (flush_eff) begin
            count_nx = '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   count_nx = count_q + 1'b1;
                2'b01:   count_nx = count_q - 1'b1;
                default: count_nx = count_q;
            endcase
        end
    end

    always_comb begin
        uflow_nx = uflow_q;
        if (uf_set)           uflow_nx = 1'b1;
        else if (uflow_clr_i) uflow_nx = 1'b0;
    end

    // occupancy state transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (count_nx == cap)     state_nx = Q_FULL;   // fill_last
                else if (count_nx != '0) state_nx = Q_PART;   // fill
            end
            Q_PART: begin
                if (count_nx == '0)      state_nx = Q_EMPTY;  // drain_last / flush
                else if (count_nx == cap) state_nx = Q_FULL;  // fill_last
            end
            Q_FULL: begin
                if (count_nx == '0)      state_nx = Q_EMPTY;  // drain_last / flush
                else if (count_nx != cap) state_nx = Q_PART;  // drain
            end
            default: state_nx = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            count_q <= '0;
            uflow_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            count_q <= count_nx;
            uflow_q <= uflow_nx;
        end
    end

    // outputs decoded from the state register
    always_comb begin
        head_valid_o = 1'b0;
        not_full_o   = 1'b1;
        unique case (state_q)
            Q_EMPTY: begin head_valid_o = 1'b0; not_full_o = 1'b1; end
            Q_PART:  begin head_valid_o = 1'b1; not_full_o = 1'b1; end
            Q_FULL:  begin head_valid_o = 1'b1; not_full_o = 1'b0; end
            default: begin head_valid_o = 1'b0; not_full_o = 1'b1; end
        endcase
    end

    assign push_ok_o   = push_ok;
    assign pop_ok_o    = pop_ok;
    assign flush_eff_o = flush_eff;
    assign last_o      = bypass_i ? '0 : PTR_W'(DEPTH - 1);
    assign uflow_o     = uflow_q;
    assign count_o     = count_q;

    // R10
    full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        not_full_o == (count_q < cap));
    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= cap);
    // R6
    uflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uflow_q) |-> $past(pop_i && count_q == '0));
    // R7
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && !bypass_i) |=> count_q == '0);
    // R9
    bypass_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_i && flush_i && !push_i && !pop_i) |=> $stable(count_q));
    // R5
    pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(count_q));
endmodule

// File: rtl/spi_txq.sv
module spi_txq
    import spi_txq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass_i,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [CMD_W-1:0]  push_cmd_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    input  logic              uflow_clr_i,
    output logic              head_valid_o,
    output logic [CMD_W-1:0]  head_cmd_o,
    output logic [DATA_W-1:0] head_data_o,
    output logic              not_full_o,
    output logic              uflow_o,
    output logic [CNT_W-1:0]  count_o
);
    logic             push_ok, pop_ok, flush_eff;
    logic [PTR_W-1:0] last_idx, wr_idx, rd_idx;
    txq_entry_t       wr_word, rd_word;

    assign wr_word.cmd  = push_cmd_i;
    assign wr_word.data = push_data_i;

    txq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .bypass_i(bypass_i), .flush_i(flush_i),
        .push_i(push_i), .pop_i(pop_i), .uflow_clr_i(uflow_clr_i),
        .push_ok_o(push_ok), .pop_ok_o(pop_ok), .flush_eff_o(flush_eff),
        .last_o(last_idx), .head_valid_o(head_valid_o),
        .not_full_o(not_full_o), .uflow_o(uflow_o), .count_o(count_o)
    );

    txq_ptr #(.DEPTH(DEPTH)) wptr_i (
        .clk(clk), .rst_n(rst_n), .adv_i(push_ok), .clr_i(flush_eff),
        .last_i(last_idx), .ptr_o(wr_idx)
    );

    txq_ptr #(.DEPTH(DEPTH)) rptr_i (
        .clk(clk), .rst_n(rst_n), .adv_i(pop_ok), .clr_i(flush_eff),
        .last_i(last_idx), .ptr_o(rd_idx)
    );

    txq_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(push_ok), .wr_idx_i(wr_idx),
        .wr_word_i(wr_word), .rd_idx_i(rd_idx), .rd_word_o(rd_word)
    );

    assign head_cmd_o  = rd_word.cmd;
    assign head_data_o = rd_word.data;
endmodule

// File: tb/spi_txq_tb_top.sv
module spi_txq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bypass = 1'b0, flush = 1'b0, push = 1'b0, pop = 1'b0, uclr = 1'b0;
    logic [15:0] pcmd = '0, pdata = '0;
    logic        hvalid, nfull, uflow;
    logic [15:0] hcmd, hdata;
    logic [4:0]  count;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string cur_req = "R1";

    logic [31:0] mq[$];
    bit          m_uf = 0;

    always #5 clk = ~clk;

    spi_txq dut_i (
        .clk(clk), .rst_n(rst_n), .bypass_i(bypass), .flush_i(flush),
        .push_i(push), .push_cmd_i(pcmd), .push_data_i(pdata), .pop_i(pop),
        .uflow_clr_i(uclr), .head_valid_o(hvalid), .head_cmd_o(hcmd),
        .head_data_o(hdata), .not_full_o(nfull), .uflow_o(uflow), .count_o(count)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int cap;
        cap = bypass ? 1 : 16;
        chk("count", 32'(count), 32'(mq.size()));
        chk("not_full", 32'(nfull), 32'(mq.size() < cap));
        chk("uflow", 32'(uflow), 32'(m_uf));
        chk("head_valid", 32'(hvalid), 32'(mq.size() != 0));
        if (mq.size() != 0) chk("head", {hcmd, hdata}, mq[0]);
    endtask

    // behavioural reference update using the inputs of the cycle just clocked
    task automatic model_update();
        int  cap;
        bit  was_empty;
        cap = bypass ? 1 : 16;
        was_empty = (mq.size() == 0);
        if (flush && !bypass) begin
            mq.delete();
            if (uclr) m_uf = 0;
        end else begin
            bit pok, qok;
            pok = push && (mq.size() < cap);
            qok = pop && !was_empty;
            if (pop && was_empty) m_uf = 1;
            else if (uclr)        m_uf = 0;
            if (qok) void'(mq.pop_front());
            if (pok) mq.push_back({pcmd, pdata});
        end
    endtask

    task automatic step(input bit p, input logic [15:0] c, input logic [15:0] d,
                        input bit q, input bit f, input bit cl);
        push = p; pcmd = c; pdata = d; pop = q; flush = f; uclr = cl;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset(input bit byp);
        rst_n = 1'b0; bypass = byp;
        push = 0; pop = 0; flush = 0; uclr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mq.delete(); m_uf = 0;
        cur_req = "R1";
        compare_all();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                mismatched++;
                $display("FAIL watchdog all-requirements actual=timeout expected=finish");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        do_reset(0);

        cur_req = "R2";
        for (int i = 0; i < 16; i++) step(1, 16'hC000 + 16'(i), 16'hD100 + 16'(i*3), 0, 0, 0);
        cur_req = "R10";
        chk("not_full_at_16", 32'(nfull), 32'd0);
        cur_req = "R4";
        step(1, 16'hBAD0, 16'hBAD1, 0, 0, 0);
        step(1, 16'hBAD2, 16'hBAD3, 0, 0, 0);
        cur_req = "R5";
        step(1, 16'h5555, 16'hAAAA, 1, 0, 0);
        step(1, 16'h6666, 16'hBBBB, 1, 0, 0);
        cur_req = "R3";
        for (int i = 0; i < 17; i++) step(0, 0, 0, 1, 0, 0);
        cur_req = "R6";
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(1, 16'h0101, 16'h0202, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        chk("uflow_sticky", 32'(uflow), 32'd1);
        step(0, 0, 0, 1, 0, 1);
        chk("uflow_set_wins", 32'(uflow), 32'd1);
        step(0, 0, 0, 0, 0, 1);
        chk("uflow_cleared", 32'(uflow), 32'd0);
        cur_req = "R7";
        for (int i = 0; i < 5; i++) step(1, 16'h7000 + 16'(i), 16'h7100, 0, 0, 0);
        step(1, 16'hEEEE, 16'hEEEE, 1, 1, 0);
        chk("flush_count", 32'(count), 32'd0);
        step(1, 16'h1234, 16'h5678, 0, 0, 0);
        cur_req = "R5";
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 3) != 0, 16'($urandom), 16'($urandom),
                 ($urandom % 3) == 0, ($urandom % 97) == 0, ($urandom % 11) == 0);
        end

        do_reset(1);
        cur_req = "R8";
        step(1, 16'hA1A1, 16'hB1B1, 0, 0, 0);
        chk("bypass_not_full", 32'(nfull), 32'd0);
        step(1, 16'hA2A2, 16'hB2B2, 0, 0, 0);
        cur_req = "R9";
        step(0, 0, 0, 0, 1, 0);
        chk("bypass_flush_count", 32'(count), 32'd1);
        chk("bypass_flush_head", {hcmd, hdata}, 32'hA1A1B1B1);
        cur_req = "R8";
        step(1, 16'hA3A3, 16'hB3B3, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(1, 16'hA4A4, 16'hB4B4, 0, 0, 0);
        chk("bypass_refill", {hcmd, hdata}, 32'hA4A4B4B4);
        cur_req = "R10";
        for (int i = 0; i < 300; i++) begin
            step(($urandom % 2) != 0, 16'($urandom), 16'($urandom),
                 ($urandom % 2) == 0, ($urandom % 5) == 0, ($urandom % 7) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule